// File: doc/BRIEF.md
# Multi-Pin Switch Debouncer with Shared Window Timer

This block filters N slow input pins, such as mechanical keys or a slow serial line, so that contact bounce produces no spurious events. All pins share one window timer. Any level change on a pin that has filtering enabled restarts that timer. Each pin can be filtered or passed straight through, and a single mode bit picks one of two filtering behaviours.

In stable mode, the filtered outputs of all enabled pins hold their values until every enabled pin has been quiet for a whole window. They then load the settled levels together. Pulses shorter than the window never reach the output. A pin that bounces and returns to its starting level gives no event.

In fast mode, the first edge on an enabled pin reaches the output at once. The pin is then locked, and its later edges are ignored until the window ends. Every edge still restarts the timer, including an ignored one. When the window expires, each locked pin is released and its output reloads the current input level, so a change made during lockout is not lost.

The window length is a count times a time base. A select input picks one of two prescaler divisors, meant for a millisecond key range and a microsecond serial-line range. The prescaler advances only on cycles where the tick-enable input is high. Settings may only be changed while all pin enables are clear.

Top module: `pin_debounce`

## Requirements
- R1: After reset is released, pins_o takes the synchronized pin levels by the third rising edge. evt_o stays zero through this warm-up.
- R2: Pin i is disabled when en_i[i] is 0. Its pins_o[i] then follows pins_i[i] three rising edges after the input changes, with an evt_o[i] pulse. Its edges do not restart the timer.
- R3: Window W is max(time_cnt_i,1) times the divisor, in clock cycles. In stable mode (mode_i=0), let edge k be the first rising edge after the last change on any enabled pin. The enabled outputs load the input levels at rising edge k+2+W and hold their values before that edge.
- R4: In stable mode, a pulse on an enabled pin that returns to its starting level within the window leaves pins_o unchanged and produces no evt_o pulse.
- R5: mode_i=0 selects stable mode and mode_i=1 selects fast mode.
- R6: In fast mode, an edge on an unlocked enabled pin reaches pins_o[i] at rising edge k+2, with an evt_o[i] pulse. That pin is then locked.
- R7: In fast mode, edges on a locked pin are ignored at the output but restart the timer. At expiry, W cycles after the last enabled edge was registered, all locks clear. Each output then reloads its input and pulses evt_o where the value changed.
- R8: tbase_sel_i=0 selects divisor DIV_LONG and tbase_sel_i=1 selects DIV_SHORT. A time_cnt_i of 0 acts as 1. The timer does not advance on cycles where tick_en_i is 0.
- R9: evt_o[i] is high in exactly those cycles in which pins_o[i] has just changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | N | Raw pin levels, asynchronous |
| en_i | input | N | Per-pin filter enable |
| mode_i | input | 1 | 0 stable, 1 fast |
| time_cnt_i | input | CNT_W | Window length in prescaled ticks |
| tbase_sel_i | input | 1 | 0 long time base, 1 short time base |
| tick_en_i | input | 1 | Time-base advance enable |
| pins_o | output | N | Filtered pin levels |
| evt_o | output | N | Single-cycle change strobe per pin |

## Verification
On every cycle, the assertions check four things. Each event strobe matches a change of the filtered output. Disabled pins track the synchronized input. Enabled outputs move only at expiry in stable mode, and locked pins move only at expiry in fast mode. Each enabled edge restarts the timer from zero.

Only the bench scenarios show the exact cycle at which a window closes. This includes windows stretched by a later edge on another pin and windows paused by the tick enable. The same holds for glitch suppression and for the reload of a level that changed during lockout. The bench sweeps both time bases over several counts, including zero, with a small divisor, so these timings are computed exactly.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic {
    PD_STABLE = 1'b0,
    PD_FAST   = 1'b1
  } pd_mode_e;

  function automatic int unsigned pd_max(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pd_timer.sv
module pd_timer #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned DIV_LONG  = 50000,
  parameter int unsigned DIV_SHORT = 250
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_en_i,
  input  logic             tbase_sel_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o
);
  import pd_pkg::*;

  localparam int unsigned DIV_MAX = pd_max(DIV_LONG, DIV_SHORT);
  localparam int unsigned PW      = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;

  logic [PW-1:0]    pre_q, div_m1;
  logic [CNT_W-1:0] cnt_q, lim_m1;
  logic             run_q, tick, last;

  assign div_m1 = tbase_sel_i ? PW'(DIV_SHORT - 1) : PW'(DIV_LONG - 1);
  // zero count is treated as a one-tick window
  assign lim_m1 = (limit_i == '0) ? '0 : limit_i - 1'b1;

  assign tick     = run_q & tick_en_i & (pre_q == div_m1);
  assign last     = (cnt_q == lim_m1);
  assign expire_o = tick & last & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      pre_q <= '0;
    end else if (restart_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      pre_q <= '0;
    end else if (run_q && tick_en_i) begin
      if (pre_q == div_m1) begin
        pre_q <= '0;
        if (last) begin
          run_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign run_o = run_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/pd_lane.sv
module pd_lane (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            warm_i,
  input  logic            sync_i,
  input  logic            edge_i,
  input  logic            en_i,
  input  pd_pkg::pd_mode_e mode_i,
  input  logic            expire_i,
  output logic            out_o,
  output logic            evt_o,
  output logic            lock_o
);
  import pd_pkg::*;

  logic out_q, evt_q, lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= 1'b0;
      evt_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (!warm_i) begin
        out_q  <= sync_i;
        lock_q <= 1'b0;
      end else if (!en_i) begin
        out_q  <= sync_i;
        evt_q  <= out_q ^ sync_i;
        lock_q <= 1'b0;
      end else if (mode_i == PD_FAST) begin
        if (expire_i) begin
          out_q  <= sync_i;
          evt_q  <= out_q ^ sync_i;
          lock_q <= 1'b0;
        end else if (edge_i && !lock_q) begin
          out_q  <= sync_i;
          evt_q  <= 1'b1;
          lock_q <= 1'b1;
        end
      end else begin
        lock_q <= 1'b0;
        if (expire_i) begin
          out_q <= sync_i;
          evt_q <= out_q ^ sync_i;
        end
      end
    end
  end

  assign out_o  = out_q;
  assign evt_o  = evt_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/pin_debounce.sv
module pin_debounce #(
  parameter int unsigned N         = 8,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned DIV_LONG  = 50000,
  parameter int unsigned DIV_SHORT = 250
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     pins_i,
  input  logic [N-1:0]     en_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] time_cnt_i,
  input  logic             tbase_sel_i,
  input  logic             tick_en_i,
  output logic [N-1:0]     pins_o,
  output logic [N-1:0]     evt_o
);
  import pd_pkg::*;

  logic [N-1:0]     sync_s, sync_q, edge_v, lock;
  logic [1:0]       warm_q;
  logic             warm_done, restart, expire, run;
  logic [CNT_W-1:0] cnt;
  pd_mode_e         mode;

  assign mode = pd_mode_e'(mode_i);

  pd_sync #(.W(N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (sync_s)
  );

  // hold lanes in load-through until the synchronizer holds real data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm_q <= '0;
      sync_q <= '0;
    end else begin
      sync_q <= sync_s;
      if (!warm_done) warm_q <= warm_q + 1'b1;
    end
  end

  assign warm_done = (warm_q == 2'd3);
  assign edge_v    = sync_s ^ sync_q;
  assign restart   = warm_done & |(edge_v & en_i);

  pd_timer #(
    .CNT_W    (CNT_W),
    .DIV_LONG (DIV_LONG),
    .DIV_SHORT(DIV_SHORT)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart),
    .tick_en_i  (tick_en_i),
    .tbase_sel_i(tbase_sel_i),
    .limit_i    (time_cnt_i),
    .expire_o   (expire),
    .run_o      (run),
    .cnt_o      (cnt)
  );

  for (genvar i = 0; i < N; i++) begin : g_lane
    pd_lane u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .warm_i  (warm_done),
      .sync_i  (sync_s[i]),
      .edge_i  (edge_v[i]),
      .en_i    (en_i[i]),
      .mode_i  (mode),
      .expire_i(expire),
      .out_o   (pins_o[i]),
      .evt_o   (evt_o[i]),
      .lock_o  (lock[i])
    );
  end
endmodule

// File: rtl/pd_chk.sv
module pd_chk #(
  parameter int unsigned N     = 8,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N-1:0]     en_i,
  input logic             mode_i,
  input logic [N-1:0]     pins_o,
  input logic [N-1:0]     evt_o,
  input logic [N-1:0]     sync_s,
  input logic [N-1:0]     sync_q,
  input logic [N-1:0]     lock,
  input logic             expire,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic             warm_done
);
  assert_no_evt_warm_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !warm_done |-> evt_o == '0);

  assert_evt_marks_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_done && $past(warm_done)) |-> evt_o == (pins_o ^ $past(pins_o)));

  assert_disabled_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_done |=> ((pins_o ^ $past(sync_s)) & $past(~en_i)) == '0);

  assert_stable_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_done && !mode_i && !expire) |=> ((pins_o ^ $past(pins_o)) & $past(en_i)) == '0);

  assert_lock_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_done && mode_i && !expire) |=>
      ((pins_o ^ $past(pins_o)) & $past(en_i & lock)) == '0);

  assert_edge_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_done && ((sync_s ^ sync_q) & en_i) != '0) |=> (run && cnt == '0));
endmodule

bind pin_debounce pd_chk #(.N(N), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .mode_i   (mode_i),
  .pins_o   (pins_o),
  .evt_o    (evt_o),
  .sync_s   (sync_s),
  .sync_q   (sync_q),
  .lock     (lock),
  .expire   (expire),
  .run      (run),
  .cnt      (cnt),
  .warm_done(warm_done)
);

// File: tb/sim_pin_debounce.sv
module sim_pin_debounce;
  localparam int N  = 4;
  localparam int DL = 4;
  localparam int DS = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pins = 4'b0101;
  logic [N-1:0] en = '0;
  logic         mode = 1'b0;
  logic [7:0]   tcnt = 8'd3;
  logic         tsel = 1'b0;
  logic         tick = 1'b1;
  logic [N-1:0] pins_o, evt_o;

  int tests = 0;
  int fails = 0;
  int evt_total = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pin_debounce #(.N(N), .CNT_W(8), .DIV_LONG(DL), .DIV_SHORT(DS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .en_i(en), .mode_i(mode),
    .time_cnt_i(tcnt), .tbase_sel_i(tsel), .tick_en_i(tick),
    .pins_o(pins_o), .evt_o(evt_o)
  );

  always @(negedge clk) evt_total += $countones(evt_o);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [N-1:0] e, input logic m, input logic [7:0] t, input logic s);
    en = '0;
    step(1);
    mode = m; tcnt = t; tsel = s;
    step(1);
    en = e;
    step(1);
  endtask

  function automatic int win(input int t, input logic s);
    return ((t == 0) ? 1 : t) * (s ? DS : DL);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] old;
    int w, e0;
    step(3);
    rst_n = 1'b1;
    step(4);
    chk(pins_o == 4'b0101, "R1 reset load", pins_o, 4'b0101);
    chk(evt_total == 0, "R1 no warm-up event", evt_total, 0);

    // R3 R8 R9 sweep over time base and count
    for (int s = 0; s < 2; s++) begin
      for (int j = 0; j < 5; j++) begin
        int t;
        int p;
        t = (j == 4) ? 5 : j;
        p = (s * 5 + j) % N;
        cfg(4'hF, 1'b0, 8'(t), s[0]);
        w = win(t, s[0]);
        old = pins;
        pins[p] = ~pins[p];
        step(2 + w);
        chk(pins_o == old, "R3 R8 hold before window end", pins_o, old);
        step(1);
        chk(pins_o == pins, "R3 R8 update at window end", pins_o, pins);
        chk(evt_o == (4'b1 << p), "R9 event at update", evt_o, 4'b1 << p);
        step(1);
        chk(evt_o == '0, "R9 event single cycle", evt_o, 0);
        step(4);
      end
    end

    // R3 shared restart by a second enabled pin
    cfg(4'hF, 1'b0, 8'd3, 1'b0);
    w = win(3, 1'b0);
    old = pins;
    pins[0] = ~pins[0];
    step(5);
    pins[1] = ~pins[1];
    step(2 + w);
    chk(pins_o == old, "R3 restart holds both", pins_o, old);
    step(1);
    chk(pins_o == pins, "R3 both update together", pins_o, pins);
    chk(evt_o == 4'b0011, "R9 joint events", evt_o, 4'b0011);
    step(4);

    // R2 disabled pin passes through and does not restart the timer
    cfg(4'b0001, 1'b0, 8'd3, 1'b0);
    old = pins;
    pins[0] = ~pins[0];
    step(4);
    pins[3] = ~pins[3];
    step(3);
    chk(pins_o[3] == pins[3], "R2 disabled pass-through", pins_o[3], pins[3]);
    chk(evt_o == 4'b1000, "R2 disabled event", evt_o, 4'b1000);
    step(w - 5);
    chk(pins_o[0] == old[0], "R2 R3 enabled still held", pins_o[0], old[0]);
    step(1);
    chk(pins_o[0] == pins[0], "R2 R3 window not restarted", pins_o[0], pins[0]);
    chk(evt_o == 4'b0001, "R3 enabled event", evt_o, 4'b0001);
    step(4);

    // R4 glitch suppression
    cfg(4'hF, 1'b0, 8'd3, 1'b0);
    e0 = evt_total;
    old = pins;
    pins[2] = ~pins[2];
    step(3);
    pins[2] = ~pins[2];
    step(w + 10);
    chk(pins_o == old, "R4 glitch output", pins_o, old);
    chk(evt_total == e0, "R4 glitch no event", evt_total, e0);

    // R8 tick enable pauses the window
    cfg(4'hF, 1'b0, 8'd2, 1'b1);
    w = win(2, 1'b1);
    old = pins;
    pins[3] = ~pins[3];
    step(3);
    tick = 1'b0;
    step(10);
    tick = 1'b1;
    step(w - 1);
    chk(pins_o == old, "R8 paused window hold", pins_o, old);
    step(1);
    chk(pins_o == pins, "R8 paused window end", pins_o, pins);
    step(4);

    // R5 R6 R7 fast mode
    cfg(4'hF, 1'b1, 8'd3, 1'b0);
    w = win(3, 1'b0);
    pins[1] = ~pins[1];
    step(3);
    chk(pins_o == pins, "R5 R6 first edge immediate", pins_o, pins);
    chk(evt_o == 4'b0010, "R6 first edge event", evt_o, 4'b0010);
    step(1);
    chk(evt_o == '0, "R9 fast event single cycle", evt_o, 0);
    pins[1] = ~pins[1];
    pins[2] = ~pins[2];
    step(3);
    chk(pins_o == (pins ^ 4'b0010), "R6 R7 other pin passes, locked pin held", pins_o, pins ^ 4'b0010);
    chk(evt_o == 4'b0100, "R6 other pin event", evt_o, 4'b0100);
    step(w - 1);
    chk(pins_o == (pins ^ 4'b0010), "R7 lockout extended by ignored edge", pins_o, pins ^ 4'b0010);
    step(1);
    chk(pins_o == pins, "R7 resample at expiry", pins_o, pins);
    chk(evt_o == 4'b0010, "R7 resample event", evt_o, 4'b0010);
    step(w + 4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule